// File: doc/BRIEF.md
# NAND Status Read Responder

This block is the device-side command and status logic of a byte-wide NAND-style flash interface. It watches command bytes written on the I/O bus and switches into one of two status modes. In either mode it puts a status byte on the bus whenever the host runs a read cycle. The first mode reports the state of a program or erase operation. The second mode reports error detection around copy-back programming.

Once a status mode is chosen, it stays in effect until the host writes a different command. While chip enable and read enable are both low, the output follows the live internal flags, so the host can poll without toggling either strobe. The memory array, the page buffers, the ECC arithmetic and the program and erase engines live elsewhere; they only feed the flag inputs.

Top module: `nand_status_responder`

## Requirements
- R1: After reset the block is in normal mode: `io_oe` is 0, and the EDC validity flag is clear, so after a later 7Bh command, bit 2 reads 0 until a validity set arrives.
- R2: After command 70h, a read returns {bit7 = NOT wp_on (protected 0), bit6 = NOT busy (ready 1), bits 5..1 = 0, bit0 = op_fail (fail 1)}.
- R3: After command 7Bh, a read returns {bit7 = NOT wp_on, bit6 = NOT busy, bits 5..3 = 0, bit2 = EDC valid (valid 1), bit1 = edc_err (error 1), bit0 = cb_fail (fail 1)}.
- R4: `io_oe` is 1 only while a status mode is active and both `ce_n` and `re_n` are low; whenever `io_oe` is 0, `io_out` is 0. The driven value therefore appears once the later of the two strobes has fallen.
- R5: While the bus is driven, `io_out` follows changes of the flag inputs in the same cycle, without any strobe toggling.
- R6: A status mode stays active across any number of read cycles and across chip enable toggles.
- R7: Writing any opcode other than 70h or 7Bh (for example 00h or 80h) returns the block to normal mode, where `io_oe` stays 0.
- R8: A command is taken only on a rising edge of `we_n` sampled while `cle` is 1 and `ce_n` is 0. A write with `cle` low or with `ce_n` high leaves the mode unchanged.
- R9: The EDC validity flag is set by a one-cycle `edc_set` pulse and cleared by `edc_clr` or by reset. When both pulses arrive in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all strobes are sampled synchronously |
| rst_n | input | 1 | Active-low asynchronous reset |
| cle | input | 1 | Command latch strobe |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; a command is taken on its rising edge |
| re_n | input | 1 | Read enable, active low |
| io_in | input | 8 | Byte from the I/O bus |
| busy | input | 1 | Internal operation in progress |
| op_fail | input | 1 | Last program or erase failed |
| wp_on | input | 1 | Write protection engaged |
| cb_fail | input | 1 | Copy-back program failed |
| edc_err | input | 1 | Error detected during read for copy-back |
| edc_set | input | 1 | Pulse: a read for copy-back finished, EDC result is valid |
| edc_clr | input | 1 | Pulse: EDC result is no longer valid |
| io_out | output | 8 | Byte driven toward the I/O bus |
| io_oe | output | 1 | Output enable for the I/O bus |

## Verification
The bench focuses on the inverted bits. A design that copied `busy` or `wp_on` straight through would read ready as 0 and protected as 1. The bench also checks that the EDC validity bit reads 0 straight after reset and after a clear that coincides with a set; a design that gave the set priority, or left the flag uninitialised, would report a stale result as valid. It checks that writes with `cle` low or `ce_n` high leave the mode alone, which catches a decoder that latches every byte and drops out of status mode on address writes. It checks that the bus is released when only one strobe is low, and that a flag change shows up while the strobes are held, which catches an output that is only sampled on a strobe edge.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_STAT   = 2'd1,
      MODE_EDC    = 2'd2
   } nsr_mode_e;
endpackage

// File: rtl/nsr_cmd_decode.sv
module nsr_cmd_decode
   import nsr_pkg::*;
#(
   parameter int          IO_W     = 8,
   parameter logic [IO_W-1:0] CMD_STAT = 8'h70,
   parameter logic [IO_W-1:0] CMD_EDC  = 8'h7B
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cle,
   input  logic            ce_n,
   input  logic            we_n,
   input  logic [IO_W-1:0] io_in,
   output nsr_mode_e       mode_q
);
   logic      we_q;
   logic      take;
   nsr_mode_e mode_d;

   // rising edge of the write strobe while command latch is up and chip selected
   assign take = cle & ~ce_n & we_n & ~we_q;

   always_comb begin
      mode_d = mode_q;
      if (take) begin
         if (io_in == CMD_STAT)     mode_d = MODE_STAT;
         else if (io_in == CMD_EDC) mode_d = MODE_EDC;
         else                       mode_d = MODE_NORMAL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q   <= 1'b1;
         mode_q <= MODE_NORMAL;
      end else begin
         we_q   <= we_n;
         mode_q <= mode_d;
      end
   end
endmodule

// File: rtl/nsr_edc_valid.sv
module nsr_edc_valid (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic valid_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q <= 1'b0;
      else if (clr_i) valid_q <= 1'b0;
      else if (set_i) valid_q <= 1'b1;
   end
endmodule

// File: rtl/nsr_status_mux.sv
module nsr_status_mux
   import nsr_pkg::*;
#(
   parameter int IO_W    = 8,
   parameter int OUT_REG = 0,
   parameter int PF_BIT  = 0,
   parameter int ERR_BIT = 1,
   parameter int VLD_BIT = 2,
   parameter int RB_BIT  = 6,
   parameter int WP_BIT  = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  nsr_mode_e       mode,
   input  logic            ce_n,
   input  logic            re_n,
   input  logic            busy,
   input  logic            op_fail,
   input  logic            wp_on,
   input  logic            cb_fail,
   input  logic            edc_err,
   input  logic            edc_vld,
   output logic [IO_W-1:0] io_out,
   output logic            io_oe
);
   logic [IO_W-1:0] stat_byte;
   logic [IO_W-1:0] edc_byte;
   logic [IO_W-1:0] sel_byte;
   logic            drive;

   always_comb begin
      stat_byte         = '0;
      stat_byte[PF_BIT] = op_fail;
      stat_byte[RB_BIT] = ~busy;
      stat_byte[WP_BIT] = ~wp_on;
      edc_byte          = '0;
      edc_byte[PF_BIT]  = cb_fail;
      edc_byte[ERR_BIT] = edc_err;
      edc_byte[VLD_BIT] = edc_vld;
      edc_byte[RB_BIT]  = ~busy;
      edc_byte[WP_BIT]  = ~wp_on;
   end

   assign drive    = (mode != MODE_NORMAL) & ~ce_n & ~re_n;
   assign sel_byte = !drive ? '0 : (mode == MODE_EDC) ? edc_byte : stat_byte;

   generate
      if (OUT_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               io_out <= '0;
               io_oe  <= 1'b0;
            end else begin
               io_out <= sel_byte;
               io_oe  <= drive;
            end
         end
      end else begin : g_comb
         assign io_out = sel_byte;
         assign io_oe  = drive;
      end
   endgenerate
endmodule

// File: rtl/nand_status_responder.sv
module nand_status_responder
   import nsr_pkg::*;
#(
   parameter int IO_W     = 8,
   parameter logic [IO_W-1:0] CMD_STAT = 8'h70,
   parameter logic [IO_W-1:0] CMD_EDC  = 8'h7B,
   parameter int OUT_REG  = 0,
   parameter int PF_BIT   = 0,
   parameter int ERR_BIT  = 1,
   parameter int VLD_BIT  = 2,
   parameter int RB_BIT   = 6,
   parameter int WP_BIT   = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cle,
   input  logic            ce_n,
   input  logic            we_n,
   input  logic            re_n,
   input  logic [IO_W-1:0] io_in,
   input  logic            busy,
   input  logic            op_fail,
   input  logic            wp_on,
   input  logic            cb_fail,
   input  logic            edc_err,
   input  logic            edc_set,
   input  logic            edc_clr,
   output logic [IO_W-1:0] io_out,
   output logic            io_oe
);
   localparam int MAX_BIT = IO_W - 1;

   generate
      if (IO_W < 3) begin : g_bad_width
         $fatal(1, "IO_W too small for the status layout");
      end
      if (PF_BIT > MAX_BIT || ERR_BIT > MAX_BIT || VLD_BIT > MAX_BIT ||
          RB_BIT > MAX_BIT || WP_BIT > MAX_BIT) begin : g_bad_pos
         $fatal(1, "status bit position beyond bus width");
      end
      if (PF_BIT == ERR_BIT || PF_BIT == VLD_BIT || PF_BIT == RB_BIT ||
          PF_BIT == WP_BIT || ERR_BIT == VLD_BIT || ERR_BIT == RB_BIT ||
          ERR_BIT == WP_BIT || VLD_BIT == RB_BIT || VLD_BIT == WP_BIT ||
          RB_BIT == WP_BIT) begin : g_bad_overlap
         $fatal(1, "status bit positions overlap");
      end
      if (CMD_STAT == CMD_EDC) begin : g_bad_cmd
         $fatal(1, "status opcodes must differ");
      end
   endgenerate

   nsr_mode_e mode_q;
   logic      edc_vld;

   nsr_cmd_decode #(.IO_W(IO_W), .CMD_STAT(CMD_STAT), .CMD_EDC(CMD_EDC)) u_dec (
      .clk(clk), .rst_n(rst_n), .cle(cle), .ce_n(ce_n), .we_n(we_n),
      .io_in(io_in), .mode_q(mode_q)
   );

   nsr_edc_valid u_vld (
      .clk(clk), .rst_n(rst_n), .set_i(edc_set), .clr_i(edc_clr), .valid_q(edc_vld)
   );

   nsr_status_mux #(
      .IO_W(IO_W), .OUT_REG(OUT_REG), .PF_BIT(PF_BIT), .ERR_BIT(ERR_BIT),
      .VLD_BIT(VLD_BIT), .RB_BIT(RB_BIT), .WP_BIT(WP_BIT)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .ce_n(ce_n), .re_n(re_n),
      .busy(busy), .op_fail(op_fail), .wp_on(wp_on), .cb_fail(cb_fail),
      .edc_err(edc_err), .edc_vld(edc_vld), .io_out(io_out), .io_oe(io_oe)
   );
endmodule

// File: rtl/nsr_checker.sv
module nsr_checker
   import nsr_pkg::*;
#(
   parameter int IO_W     = 8,
   parameter logic [IO_W-1:0] CMD_STAT = 8'h70,
   parameter logic [IO_W-1:0] CMD_EDC  = 8'h7B,
   parameter int OUT_REG  = 0,
   parameter int RB_BIT   = 6,
   parameter int WP_BIT   = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cle,
   input logic            ce_n,
   input logic            we_n,
   input logic            re_n,
   input logic [IO_W-1:0] io_in,
   input logic            busy,
   input logic            wp_on,
   input logic            edc_set,
   input logic            edc_clr,
   input nsr_mode_e       mode_q,
   input logic            edc_vld,
   input logic [IO_W-1:0] io_out,
   input logic            io_oe
);
   logic we_prev;
   logic wr_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_prev <= 1'b1;
      else        we_prev <= we_n;
   end
   assign wr_edge = cle && !ce_n && we_n && !we_prev;

   generate
      if (OUT_REG == 0) begin : g_comb_chk
         p_oe_needs_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
            io_oe |-> (!ce_n && !re_n));
         p_live_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
            io_oe |-> (io_out[RB_BIT] == !busy && io_out[WP_BIT] == !wp_on));
      end
   endgenerate

   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !io_oe |-> (io_out == '0));

   p_take_stat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_edge && io_in == CMD_STAT) |=> (mode_q == MODE_STAT));

   p_take_edc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_edge && io_in == CMD_EDC) |=> (mode_q == MODE_EDC));

   p_other_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_edge && io_in != CMD_STAT && io_in != CMD_EDC) |=> (mode_q == MODE_NORMAL));

   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_edge |=> $stable(mode_q));

   p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      edc_clr |=> !edc_vld);

   p_set_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (edc_set && !edc_clr) |=> edc_vld);
endmodule

bind nand_status_responder nsr_checker #(
   .IO_W(IO_W), .CMD_STAT(CMD_STAT), .CMD_EDC(CMD_EDC), .OUT_REG(OUT_REG),
   .RB_BIT(RB_BIT), .WP_BIT(WP_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cle(cle), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
   .io_in(io_in), .busy(busy), .wp_on(wp_on), .edc_set(edc_set),
   .edc_clr(edc_clr), .mode_q(mode_q), .edc_vld(edc_vld), .io_out(io_out),
   .io_oe(io_oe)
);

// File: tb/sim_nand_status_responder.sv
`timescale 1ns/1ps
module sim_nand_status_responder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cle = 1'b0, ce_n = 1'b1, we_n = 1'b1, re_n = 1'b1;
   logic [7:0] io_in = 8'h00;
   logic       busy = 1'b0, op_fail = 1'b0, wp_on = 1'b0;
   logic       cb_fail = 1'b0, edc_err = 1'b0, edc_set = 1'b0, edc_clr = 1'b0;
   logic [7:0] io_out;
   logic       io_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   nand_status_responder u0 (
      .clk(clk), .rst_n(rst_n), .cle(cle), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
      .io_in(io_in), .busy(busy), .op_fail(op_fail), .wp_on(wp_on),
      .cb_fail(cb_fail), .edc_err(edc_err), .edc_set(edc_set), .edc_clr(edc_clr),
      .io_out(io_out), .io_oe(io_oe)
   );

   task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] stat_exp();
      return {~wp_on, ~busy, 5'b0, op_fail};
   endfunction

   function automatic logic [7:0] edc_exp(logic vld);
      return {~wp_on, ~busy, 3'b0, vld, edc_err, cb_fail};
   endfunction

   // command write: strobe low for one cycle, rising edge seen at next posedge
   task automatic write_cmd(logic [7:0] op, logic c, logic ce);
      @(negedge clk); cle = c; ce_n = ce; io_in = op; we_n = 1'b0; re_n = 1'b1;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); cle = 1'b0; ce_n = 1'b1;
   endtask

   task automatic read_start();
      @(negedge clk); ce_n = 1'b0; re_n = 1'b0; #1;
   endtask

   task automatic read_end();
      @(negedge clk); re_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic pulse(bit s, bit c);
      @(negedge clk); edc_set = s; edc_clr = c;
      @(negedge clk); edc_set = 1'b0; edc_clr = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      check("R1 oe after reset", {1'b0, io_oe}, 9'h000);
      write_cmd(8'h7B, 1'b1, 1'b0);
      read_start();
      check("R1 validity clear after reset", {1'b0, io_out[2]}, 9'h000);
      read_end();
   endtask

   task automatic t_status();
      write_cmd(8'h70, 1'b1, 1'b0);
      busy = 1'b0; wp_on = 1'b0; op_fail = 1'b0;
      read_start();
      check("R2 ready unprotected pass", {io_oe, io_out}, {1'b1, 8'hC0});
      read_end();
      busy = 1'b1; wp_on = 1'b1; op_fail = 1'b1;
      read_start();
      check("R2 busy protected fail", {io_oe, io_out}, {1'b1, 8'h01});
      read_end();
      busy = 1'b0; op_fail = 1'b0; wp_on = 1'b0;
   endtask

   task automatic t_edc();
      write_cmd(8'h7B, 1'b1, 1'b0);
      pulse(1'b1, 1'b0);
      cb_fail = 1'b1; edc_err = 1'b0;
      read_start();
      check("R3 edc byte fail valid", {io_oe, io_out}, {1'b1, edc_exp(1'b1)});
      read_end();
      cb_fail = 1'b0; edc_err = 1'b1; busy = 1'b1;
      read_start();
      check("R3 edc byte error busy", {io_oe, io_out}, {1'b1, 8'h86});
      read_end();
      busy = 1'b0; edc_err = 1'b0;
   endtask

   task automatic t_gating();
      write_cmd(8'h70, 1'b1, 1'b0);
      @(negedge clk); ce_n = 1'b0; re_n = 1'b1; #1;
      check("R4 ce only", {io_oe, io_out}, 9'h000);
      @(negedge clk); ce_n = 1'b1; re_n = 1'b0; #1;
      check("R4 re only", {io_oe, io_out}, 9'h000);
      @(negedge clk); ce_n = 1'b0; #1;
      check("R4 later strobe falls", {io_oe, io_out}, {1'b1, stat_exp()});
      read_end();
   endtask

   task automatic t_live();
      write_cmd(8'h70, 1'b1, 1'b0);
      read_start();
      check("R5 initial", {io_oe, io_out}, {1'b1, 8'hC0});
      @(negedge clk); busy = 1'b1; #1;
      check("R5 busy seen without toggle", {io_oe, io_out}, {1'b1, 8'h80});
      @(negedge clk); busy = 1'b0; op_fail = 1'b1; #1;
      check("R5 fail seen without toggle", {io_oe, io_out}, {1'b1, 8'hC1});
      read_end();
      op_fail = 1'b0;
   endtask

   task automatic t_sticky_exit();
      write_cmd(8'h70, 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) begin
         read_start();
         check("R6 stays in status mode", {io_oe, io_out}, {1'b1, 8'hC0});
         read_end();
      end
      write_cmd(8'h00, 1'b1, 1'b0);
      read_start();
      check("R7 00h leaves status", {io_oe, io_out}, 9'h000);
      read_end();
      write_cmd(8'h7B, 1'b1, 1'b0);
      write_cmd(8'h80, 1'b1, 1'b0);
      read_start();
      check("R7 80h leaves edc", {io_oe, io_out}, 9'h000);
      read_end();
   endtask

   task automatic t_ignored();
      write_cmd(8'h70, 1'b1, 1'b0);
      write_cmd(8'h00, 1'b0, 1'b0);
      read_start();
      check("R8 write with cle low ignored", {io_oe, io_out}, {1'b1, 8'hC0});
      read_end();
      write_cmd(8'h00, 1'b1, 1'b1);
      read_start();
      check("R8 write with chip deselected ignored", {io_oe, io_out}, {1'b1, 8'hC0});
      read_end();
   endtask

   task automatic t_valid();
      write_cmd(8'h7B, 1'b1, 1'b0);
      pulse(1'b1, 1'b0);
      read_start();
      check("R9 set", {1'b0, io_out[2]}, 9'h001);
      read_end();
      pulse(1'b0, 1'b1);
      read_start();
      check("R9 clear", {1'b0, io_out[2]}, 9'h000);
      read_end();
      pulse(1'b1, 1'b0);
      pulse(1'b1, 1'b1);
      read_start();
      check("R9 clear wins over set", {1'b0, io_out[2]}, 9'h000);
      read_end();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_status();
      t_edc();
      t_gating();
      t_live();
      t_sticky_exit();
      t_ignored();
      t_valid();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule